// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block lets a target device take part in the SMBus alert protocol. While the interrupt logic reports a pending alert, the block pulls the shared open-drain alert line low. The host answers an alert by issuing a receive-byte transaction to the alert response address. An alerting device acknowledges that header and then returns its own 7-bit address, most significant bit first, in the upper seven bits of the data byte.

Several devices may answer at once, so the data byte is sent with open-drain arbitration. Each transmitted 1 is checked against the sampled bus, and the first mismatch makes the block stop driving. The lowest address therefore wins. Only the winner sends a clear strobe back to the interrupt logic and releases its alert line. A loser keeps its alert pending and answers again at the next alert response cycle.

SCL and SDA arrive as already-synchronised samples, and the system clock oversamples them. The SDA output is a pull-down enable: 1 means drive the line low.

Top module: `smbus_ara_responder`

## Requirements
- R1: After synchronous reset, sda_pull_o and cleared_o are 0 and the block waits for a START condition.
- R2: alert_pull_o is 1 exactly when alert_pend_i is 1 and no successful response has completed since alert_pend_i was last 0.
- R3: After a START, the block shifts in eight header bits MSB first on SCL rising edges. If they equal 0x19 (address 0x0C with read bit 1) while its alert is pending, it pulls SDA low from the SCL falling edge after the eighth bit until the falling edge after the ninth.
- R4: The block does not acknowledge a header that carries a different address, a write bit (0), or arrives while no alert is pending, and it stays off SDA for the rest of that transaction.
- R5: After acknowledging, the block returns the byte {own_addr_i, 1'b0} MSB first. It places each bit at an SCL falling edge and pulls SDA low for a 0 and releases it for a 1.
- R6: If SDA is sampled low on an SCL rising edge while the block transmits a 1, the block stops driving for the rest of the byte, gives no clear strobe, and keeps alert_pull_o at 1.
- R7: On the SCL falling edge after the eighth data bit, if arbitration was never lost, the block releases SDA, raises cleared_o for one clock cycle and drops alert_pull_o in that same cycle, whatever acknowledge the host gives.
- R8: A START or STOP condition during a transfer releases SDA on the next clock, keeps the alert pending and gives no strobe. A START begins a new header.
- R9: sda_pull_o only goes from 0 to 1 while SCL is low.
- R10: Once a response has completed, a further alert response read gets no acknowledge until alert_pend_i has gone to 0 and back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCL and SDA |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (wired bus level) |
| alert_pend_i | input | 1 | Alert pending from the interrupt logic |
| own_addr_i | input | 7 | This device's 7-bit bus address |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| alert_pull_o | output | 1 | 1 pulls the alert line low |
| cleared_o | output | 1 | One-cycle strobe: alert was successfully answered |

## Verification
The bench drives arbitration against a modelled second alerting device with both a lower and a higher address. A design that compared the wrong bits, or kept driving after a mismatch, would corrupt the byte the host reads or would clear an alert it did not win. It aborts a response with a repeated START between data bits and a header with a STOP. A design that ignored bus conditions would keep driving SDA or would pulse the clear strobe. It also repeats the alert response read after a successful clear and sends a write header and a neighbouring address. A responder that latched too little state would acknowledge twice or would answer headers that are not its own.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [ADDR_W-1:0] ARA_ADDR = 7'h0C;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_ACK,
        ST_SEND
    } sar_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic [BYTE_W-1:0] reply_byte(input logic [ADDR_W-1:0] addr);
        return {addr, 1'b0};
    endfunction

    function automatic logic hdr_is_ara_read(input logic [BYTE_W-1:0] hdr);
        return hdr == {ARA_ADDR, 1'b1};
    endfunction

endpackage

// File: rtl/sar_bus_sense.sv
module sar_bus_sense (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output sar_pkg::bus_evt_t evt_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt_o.scl_rise = scl_i & ~scl_q;
        evt_o.scl_fall = ~scl_i & scl_q;
        evt_o.start    = scl_i & scl_q & sda_q & ~sda_i;
        evt_o.stop     = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/sar_hdr_rx.sv
module sar_hdr_rx #(
    parameter int BYTE_W = sar_pkg::BYTE_W,
    parameter int CNT_W  = sar_pkg::CNT_W
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic full_o,
    output logic ara_hit_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (shift_i && (cnt != FULL_CNT)) begin
            shreg <= {shreg[BYTE_W-2:0], bit_i};
            cnt   <= cnt + 1'b1;
        end
    end

    assign full_o    = (cnt == FULL_CNT);
    assign ara_hit_o = sar_pkg::hdr_is_ara_read(shreg);
endmodule

// File: rtl/sar_arb_tx.sv
module sar_arb_tx #(
    parameter int BYTE_W = sar_pkg::BYTE_W,
    parameter int CNT_W  = sar_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              adv_i,
    output logic              bit_o,
    output logic              next_bit_o,
    output logic              last_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (load_i) begin
            shreg <= byte_i;
            cnt   <= '0;
        end else if (adv_i) begin
            shreg <= {shreg[BYTE_W-2:0], 1'b0};
            cnt   <= cnt + 1'b1;
        end
    end

    assign bit_o      = shreg[BYTE_W-1];
    assign next_bit_o = shreg[BYTE_W-2];
    assign last_o     = (cnt == LAST_CNT);
endmodule

// File: rtl/smbus_ara_responder.sv
module smbus_ara_responder #(
    parameter int ADDR_W = sar_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              alert_pend_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              sda_pull_o,
    output logic              alert_pull_o,
    output logic              cleared_o
);
    import sar_pkg::*;

    localparam int BW = ADDR_W + 1;

    sar_state_e state;
    bus_evt_t   evt;
    logic       quiet_q;
    logic       pull_q;
    logic       clr_q;
    logic       pending;
    logic       hdr_full;
    logic       hdr_hit;
    logic       tx_bit;
    logic       tx_next;
    logic       tx_last;
    logic       tx_load;
    logic       tx_adv;
    logic       bus_cond;
    logic       arb_lost;
    logic [BW-1:0] reply;

    sar_bus_sense u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    sar_hdr_rx #(.BYTE_W(BW), .CNT_W($clog2(BW + 1))) u_hdr (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (evt.start),
        .shift_i   ((state == ST_HDR) && evt.scl_rise),
        .bit_i     (sda_i),
        .full_o    (hdr_full),
        .ara_hit_o (hdr_hit)
    );

    sar_arb_tx #(.BYTE_W(BW), .CNT_W($clog2(BW + 1))) u_tx (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tx_load),
        .byte_i     (reply),
        .adv_i      (tx_adv),
        .bit_o      (tx_bit),
        .next_bit_o (tx_next),
        .last_o     (tx_last)
    );

    assign reply    = reply_byte(own_addr_i);
    assign pending  = alert_pend_i & ~quiet_q;
    assign bus_cond = evt.start | evt.stop;
    assign arb_lost = (state == ST_SEND) && evt.scl_rise && tx_bit && !sda_i;
    assign tx_load  = (state == ST_ACK) && evt.scl_fall && !bus_cond;
    assign tx_adv   = (state == ST_SEND) && evt.scl_fall && !tx_last && !bus_cond;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pull_q  <= 1'b0;
            clr_q   <= 1'b0;
            quiet_q <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            if (!alert_pend_i) begin
                quiet_q <= 1'b0;
            end
            if (evt.start) begin
                state  <= ST_HDR;
                pull_q <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                pull_q <= 1'b0;
            end else begin
                case (state)
                    ST_HDR: begin
                        if (evt.scl_fall && hdr_full) begin
                            if (hdr_hit && pending) begin
                                state  <= ST_ACK;
                                pull_q <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            state  <= ST_SEND;
                            pull_q <= ~reply[BW-1];
                        end
                    end
                    ST_SEND: begin
                        if (arb_lost) begin
                            state  <= ST_IDLE;
                            pull_q <= 1'b0;
                        end else if (evt.scl_fall) begin
                            if (tx_last) begin
                                state   <= ST_IDLE;
                                pull_q  <= 1'b0;
                                clr_q   <= 1'b1;
                                quiet_q <= 1'b1;
                            end else begin
                                pull_q <= ~tx_next;
                            end
                        end
                    end
                    default: begin
                        state  <= ST_IDLE;
                        pull_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_pull_o   = pull_q;
    assign cleared_o    = clr_q;
    assign alert_pull_o = pending;
endmodule

// File: rtl/sar_checker.sv
module sar_checker (
    input logic               clk,
    input logic               rst,
    input logic               scl_i,
    input logic               alert_pend_i,
    input logic               sda_pull_o,
    input logic               alert_pull_o,
    input logic               cleared_o,
    input sar_pkg::bus_evt_t  evt
);
    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cleared_o |=> !cleared_o); // R7

    AST_CLEAR_DROPS_ALERT: assert property (@(posedge clk) disable iff (rst)
        cleared_o |-> !alert_pull_o); // R7

    AST_CLEAR_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        cleared_o |-> $past(evt.scl_fall)); // R7

    AST_NO_PEND_NO_ALERT: assert property (@(posedge clk) disable iff (rst)
        !alert_pend_i |-> !alert_pull_o); // R2

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !scl_i); // R9

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !sda_pull_o); // R8

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (!sda_pull_o && !cleared_o)); // R8
endmodule

bind smbus_ara_responder sar_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_i),
    .alert_pend_i (alert_pend_i),
    .sda_pull_o   (sda_pull_o),
    .alert_pull_o (alert_pull_o),
    .cleared_o    (cleared_o),
    .evt          (evt)
);

// File: tb/smbus_ara_responder_tb.sv
module smbus_ara_responder_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       host_scl    = 1'b1;
    logic       host_sda    = 1'b1;
    logic       comp_pull   = 1'b0;
    logic       comp_active = 1'b0;
    logic       alert_pend  = 1'b0;
    logic [6:0] own_addr    = 7'h2A;
    logic       sda_pull;
    logic       alert_pull;
    logic       cleared;
    logic       sda_bus;

    assign sda_bus = host_sda & ~sda_pull & ~comp_pull;

    smbus_ara_responder u_dut (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (host_scl),
        .sda_i        (sda_bus),
        .alert_pend_i (alert_pend),
        .own_addr_i   (own_addr),
        .sda_pull_o   (sda_pull),
        .alert_pull_o (alert_pull),
        .cleared_o    (cleared)
    );

    int n_checks = 0;
    int n_errs   = 0;
    int n_clears = 0;
    int r9_bad   = 0;
    logic pull_prev = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] val;
    } item_t;

    item_t exp_q[$];
    item_t got_q[$];

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_item(input string tag, input logic [7:0] v);
        item_t it;
        it.tag = tag;
        it.val = v;
        exp_q.push_back(it);
    endtask

    task automatic observe(input logic [7:0] v);
        item_t it;
        it.tag = "";
        it.val = v;
        got_q.push_back(it);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        while (got_q.size() > 0) begin
            item_t g;
            item_t e;
            g = got_q.pop_front();
            if (exp_q.size() == 0) begin
                n_checks++;
                n_errs++;
                $display("FAIL scoreboard: unexpected item got %0h expected none", g.val);
            end else begin
                e = exp_q.pop_front();
                chk(e.tag, g.val, e.val);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && cleared) n_clears++;
        if (!rst && sda_pull && !pull_prev && host_scl) r9_bad++; // R9
        pull_prev = sda_pull;
    end

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic gen_start();
        host_sda = 1'b1; half();
        host_scl = 1'b1; half();
        host_sda = 1'b0; half();
        host_scl = 1'b0; half();
    endtask

    task automatic gen_stop();
        host_sda = 1'b0; half();
        host_scl = 1'b1; half();
        host_sda = 1'b1; half();
    endtask

    task automatic wbit(input logic b);
        host_sda = b; half();
        host_scl = 1'b1; half();
        host_scl = 1'b0; half();
    endtask

    task automatic rbit(input logic cbit, output logic b);
        host_sda  = 1'b1;
        comp_pull = comp_active & ~cbit;
        half();
        host_scl = 1'b1; half();
        b = sda_bus;
        if (comp_active && cbit && !b) comp_active = 1'b0;
        host_scl = 1'b0; half();
    endtask

    task automatic ara_body(input logic [7:0] hdr, input logic comp_en, input logic [6:0] comp_addr);
        logic       b;
        logic [7:0] data;
        logic [7:0] cb;
        cb = {comp_addr, 1'b0};
        for (int i = 7; i >= 0; i--) wbit(hdr[i]);
        rbit(1'b1, b);
        observe({7'b0, b});
        comp_active = comp_en;
        for (int i = 7; i >= 0; i--) begin
            rbit(cb[i], b);
            data[i] = b;
        end
        comp_active = 1'b0;
        comp_pull   = 1'b0;
        observe(data);
        wbit(1'b1);
        gen_stop();
    endtask

    task automatic ara_txn(input logic [7:0] hdr, input logic comp_en, input logic [6:0] comp_addr);
        gen_start();
        ara_body(hdr, comp_en, comp_addr);
    endtask

    task automatic rearm();
        alert_pend = 1'b0;
        repeat (2) @(negedge clk);
        alert_pend = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int c0;
        logic b;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sda released after reset", {7'b0, sda_pull}, 8'd0);
        chk("R1 no strobe after reset", {7'b0, cleared}, 8'd0);
        chk("R2 alert idle without pending", {7'b0, alert_pull}, 8'd0);

        alert_pend = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 alert asserted", {7'b0, alert_pull}, 8'd1);

        // basic win, host NACKs the byte
        c0 = n_clears;
        expect_item("R3 ack on alert response read", 8'd0);
        expect_item("R5 own address 0x2A returned", 8'h54);
        ara_txn(8'h19, 1'b0, 7'h0);
        chk("R7 one clear strobe", 8'(n_clears - c0), 8'd1);
        chk("R7 alert released after win", {7'b0, alert_pull}, 8'd0);

        // repeat read before re-arm
        c0 = n_clears;
        expect_item("R10 no ack after completed response", 8'd1);
        expect_item("R10 bus idle byte", 8'hFF);
        ara_txn(8'h19, 1'b0, 7'h0);
        chk("R10 no extra strobe", 8'(n_clears - c0), 8'd0);

        rearm();
        chk("R2 alert back after re-arm", {7'b0, alert_pull}, 8'd1);

        // headers that must be ignored
        c0 = n_clears;
        expect_item("R4 write header not acked", 8'd1);
        expect_item("R4 write header no data", 8'hFF);
        ara_txn(8'h18, 1'b0, 7'h0);
        expect_item("R4 other address not acked", 8'd1);
        expect_item("R4 other address no data", 8'hFF);
        ara_txn(8'h1B, 1'b0, 7'h0);
        chk("R4 no strobe on foreign headers", 8'(n_clears - c0), 8'd0);
        chk("R4 alert kept", {7'b0, alert_pull}, 8'd1);

        alert_pend = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 alert follows pending low", {7'b0, alert_pull}, 8'd0);
        expect_item("R4 no ack without pending alert", 8'd1);
        expect_item("R4 no data without pending alert", 8'hFF);
        ara_txn(8'h19, 1'b0, 7'h0);
        alert_pend = 1'b1;
        repeat (2) @(negedge clk);

        // different own address, LSB must be 0
        own_addr = 7'h7F;
        c0 = n_clears;
        expect_item("R3 ack with address 0x7F", 8'd0);
        expect_item("R5 address 0x7F returned with zero LSB", 8'hFE);
        ara_txn(8'h19, 1'b0, 7'h0);
        chk("R7 strobe for 0x7F", 8'(n_clears - c0), 8'd1);
        rearm();
        own_addr = 7'h2A;

        // arbitration lost to lower address
        c0 = n_clears;
        expect_item("R3 ack before arbitration", 8'd0);
        expect_item("R6 lower competitor byte on bus", 8'h20);
        ara_txn(8'h19, 1'b1, 7'h10);
        chk("R6 no strobe when lost", 8'(n_clears - c0), 8'd0);
        chk("R6 alert kept when lost", {7'b0, alert_pull}, 8'd1);
        chk("R6 sda released when lost", {7'b0, sda_pull}, 8'd0);

        // arbitration won against higher address
        expect_item("R3 ack against higher competitor", 8'd0);
        expect_item("R6 own byte wins", 8'h54);
        ara_txn(8'h19, 1'b1, 7'h55);
        chk("R6 strobe when won", 8'(n_clears - c0), 8'd1);
        rearm();

        // repeated START in the middle of the data byte
        c0 = n_clears;
        gen_start();
        for (int i = 7; i >= 0; i--) wbit(i == 0 || i == 3 || i == 4);
        rbit(1'b1, b);
        chk("R3 ack before abort", {7'b0, b}, 8'd0);
        for (int i = 0; i < 3; i++) rbit(1'b1, b);
        gen_start();
        chk("R8 sda released after start", {7'b0, sda_pull}, 8'd0);
        chk("R8 alert kept after start", {7'b0, alert_pull}, 8'd1);
        chk("R8 no strobe on abort", 8'(n_clears - c0), 8'd0);
        expect_item("R8 new header acked after restart", 8'd0);
        expect_item("R8 full byte after restart", 8'h54);
        ara_body(8'h19, 1'b0, 7'h0);
        chk("R8 strobe after restart", 8'(n_clears - c0), 8'd1);
        rearm();

        // STOP during the header
        c0 = n_clears;
        gen_start();
        for (int i = 7; i >= 4; i--) wbit(i == 4);
        gen_stop();
        chk("R8 sda released after stop", {7'b0, sda_pull}, 8'd0);
        chk("R8 alert kept after stop", {7'b0, alert_pull}, 8'd1);
        chk("R8 no strobe after stop", 8'(n_clears - c0), 8'd0);

        repeat (3) @(negedge clk);
        chk("R9 sda pull rose only with SCL low", 8'(r9_bad), 8'd0);
        chk("scoreboard drained", 8'(exp_q.size()), 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule